// File: doc/BRIEF.md
# Three-Channel Event Timer

A free-running 32-bit up counter advances by one on each cycle where the tick-enable input is high and the global run bit is set. The tick input stands in for a slow reference clock of roughly 14.3 MHz that has been brought into the block's clock domain. Three 32-bit match comparators watch the counter. Each one belongs to its own timer channel, and each channel has a sticky interrupt status bit and an interrupt enable. A channel's interrupt line is high while both its status bit and its enable bit are set.

Channel 0 can run one-shot or periodic. In periodic mode, every match adds a programmed period to the comparator. Channels 1 and 2 can only run one-shot, and their mode bit is tied off. Software reaches all state through a single-cycle register port. Writes take effect at the next clock edge. Reads are combinational from the address.

Top module: `evt_timer`

## Requirements
- R1: After reset, the counter, the run bit, every comparator, every period, every configuration field and every status bit read 0, and `irq` is 0.
- R2: The counter (address 1) increments by exactly 1 at each clock edge where `tick` is 1 and the run bit (address 0, bit 0) is 1. When either is 0, the counter holds its value.
- R3: Counting past 0xFFFFFFFF gives 0, and counting then continues from 0.
- R4: A write to address 1 loads the counter at the next edge and has priority over counting. The write never sets a status bit, even when the loaded value equals a comparator.
- R5: A channel sets its status bit at the edge where the counter steps onto that channel's comparator value (channel n comparator at address 4·(n+1)+1). In one-shot mode the comparator does not change, so the channel does not fire again until the counter has wrapped around.
- R6: The status register at address 2 (bit n = channel n) is sticky. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged. A match and a clear in the same cycle leave the bit set.
- R7: `irq[n]` equals status bit n ANDed with the enable bit, which is bit 0 of the channel's configuration register at address 4·(n+1).
- R8: When configuration bit 1 of channel 0 is 1 (periodic mode), each match also sets the comparator to its old value plus the period register (address 6), modulo 2^32. A comparator write in the same cycle takes priority.
- R9: On channels 1 and 2, configuration bit 1 and the period register (addresses 10 and 14) ignore writes and read 0. Their comparators change only when software writes them.
- R10: Register map: 0 = run bit, 1 = counter, 2 = status. For channel n, the configuration register is at 4·(n+1), the comparator at 4·(n+1)+1, and the period at 4·(n+1)+2. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance enable from the reference rate |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 3 | Per-channel interrupt, status AND enable |

## Verification
The properties assume that the register port performs at most one access per cycle. A write to the counter or to a comparator therefore never coincides with a clear of the status register. They also assume that `tick` may be high in any cycle, including cycles with a register write. The stimulus holds `reg_we` for exactly one clock per access and always changes `reg_addr` and `reg_wdata` on the falling edge. Ticks are applied in bursts of a known length, so the expected counter value is always a plain sum. Both wrap-around cases are set up by loading the counter near 0xFFFFFFFF while the run bit is off, which keeps every load free of matches.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int CNT_W   = 32;
    localparam int ADR_RUN = 0;
    localparam int ADR_CNT = 1;
    localparam int ADR_STS = 2;
    localparam int OFS_CFG = 0;
    localparam int OFS_CMP = 1;
    localparam int OFS_PER = 2;

    typedef struct packed {
        logic             ie;
        logic             periodic;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] per;
        logic             status;
    } chan_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    typedef struct packed {
        logic run;
    } ctl_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             step
);
    ctr_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        cnt_inc = s_q.cnt + CNT_W'(1);
        step    = run && tick && !load;
        if (load)
            s_d.cnt = load_val;
        else if (step)
            s_d.cnt = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit PERIODIC_OK = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic             cfg_we,
    input  logic             cmp_we,
    input  logic             per_we,
    input  logic             clr,
    input  logic [CNT_W-1:0] wdata,
    output logic             ie,
    output logic             periodic,
    output logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] per,
    output logic             status,
    output logic             hit
);
    chan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        hit = step && (cnt_inc == s_q.cmp);
        if (cfg_we) begin
            s_d.ie       = wdata[0];
            s_d.periodic = PERIODIC_OK ? wdata[1] : 1'b0;
        end
        if (per_we && PERIODIC_OK)
            s_d.per = wdata;
        if (cmp_we)
            s_d.cmp = wdata;
        else if (hit && s_q.periodic)
            s_d.cmp = s_q.cmp + s_q.per;
        if (clr)
            s_d.status = 1'b0;
        if (hit)
            s_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ie       = s_q.ie;
    assign periodic = s_q.periodic;
    assign cmp      = s_q.cmp;
    assign per      = s_q.per;
    assign status   = s_q.status;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int          NUM_CH        = 3,
    parameter logic [31:0] PERIODIC_MASK = 32'h1,
    localparam int         ADDR_W        = $clog2(4 * (NUM_CH + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int SEL_W = ADDR_W - 2;

    ctl_t ctl_d, ctl_q;

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             step;
    logic [NUM_CH-1:0] sts_clr;
    logic [NUM_CH-1:0] ch_status, ch_hit, ch_ie, ch_per_mode;
    logic [CNT_W-1:0]  ch_cmp [NUM_CH];
    logic [CNT_W-1:0]  ch_per [NUM_CH];

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = reg_we && (reg_addr == ADDR_W'(ADR_CNT));
        sts_clr  = (reg_we && (reg_addr == ADDR_W'(ADR_STS)))
                   ? reg_wdata[NUM_CH-1:0] : '0;
        if (reg_we && (reg_addr == ADDR_W'(ADR_RUN)))
            ctl_d.run = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    evt_counter u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctl_q.run),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (reg_wdata),
        .cnt      (cnt_q),
        .cnt_inc  (cnt_inc),
        .step     (step)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic ch_sel;
        assign ch_sel = reg_we && (reg_addr[ADDR_W-1:2] == SEL_W'(n + 1));

        evt_channel #(.PERIODIC_OK(PERIODIC_MASK[n])) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step),
            .cnt_inc  (cnt_inc),
            .cfg_we   (ch_sel && (reg_addr[1:0] == 2'(OFS_CFG))),
            .cmp_we   (ch_sel && (reg_addr[1:0] == 2'(OFS_CMP))),
            .per_we   (ch_sel && (reg_addr[1:0] == 2'(OFS_PER))),
            .clr      (sts_clr[n]),
            .wdata    (reg_wdata),
            .ie       (ch_ie[n]),
            .periodic (ch_per_mode[n]),
            .cmp      (ch_cmp[n]),
            .per      (ch_per[n]),
            .status   (ch_status[n]),
            .hit      (ch_hit[n])
        );
    end

    assign irq = ch_status & ch_ie;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADR_RUN))
            reg_rdata[0] = ctl_q.run;
        else if (reg_addr == ADDR_W'(ADR_CNT))
            reg_rdata = cnt_q;
        else if (reg_addr == ADDR_W'(ADR_STS))
            reg_rdata[NUM_CH-1:0] = ch_status;
        for (int n = 0; n < NUM_CH; n++) begin
            if (reg_addr[ADDR_W-1:2] == SEL_W'(n + 1)) begin
                case (reg_addr[1:0])
                    2'(OFS_CFG): reg_rdata[1:0] = {ch_per_mode[n], ch_ie[n]};
                    2'(OFS_CMP): reg_rdata = ch_cmp[n];
                    2'(OFS_PER): reg_rdata = ch_per[n];
                    default:     reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              run,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CNT_W-1:0]  reg_wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [2:0]        status,
    input logic              hit0,
    input logic              per_mode0,
    input logic [CNT_W-1:0]  cmp0,
    input logic [CNT_W-1:0]  cmp1,
    input logic [CNT_W-1:0]  cmp2,
    input logic [CNT_W-1:0]  per0
);
    logic cnt_wr, sts_wr, cmp0_wr, cmp1_wr, cmp2_wr;
    assign cnt_wr  = reg_we && (reg_addr == ADDR_W'(ADR_CNT));
    assign sts_wr  = reg_we && (reg_addr == ADDR_W'(ADR_STS));
    assign cmp0_wr = reg_we && (reg_addr == ADDR_W'(4 + OFS_CMP));
    assign cmp1_wr = reg_we && (reg_addr == ADDR_W'(8 + OFS_CMP));
    assign cmp2_wr = reg_we && (reg_addr == ADDR_W'(12 + OFS_CMP));

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !cnt_wr) |=> $stable(cnt)); // R2
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(reg_wdata))); // R4
    AST_LOAD_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> ((status & ~$past(status)) == 3'b000)); // R4
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> ((status & $past(status)) == $past(status))); // R6
    AST_PERIOD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0 && per_mode0 && !cmp0_wr) |=> (cmp0 == $past(cmp0) + $past(per0))); // R8
    AST_CH1_CMP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp1_wr |=> $stable(cmp1)); // R9
    AST_CH2_CMP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp2_wr |=> $stable(cmp2)); // R9
endmodule

bind evt_timer evt_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (ctl_q.run),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt       (cnt_q),
    .status    (ch_status[2:0]),
    .hit0      (ch_hit[0]),
    .per_mode0 (ch_per_mode[0]),
    .cmp0      (ch_cmp[0]),
    .cmp1      (ch_cmp[1]),
    .cmp2      (ch_cmp[2]),
    .per0      (ch_per[0])
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    evt_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  kind;   // 0 write, 1 tick burst, 2 read check
        logic [3:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd0,  32'd0,   4'd10}, // R10 run off
        '{2'd0, 4'd1,  32'd10,  4'd4},  // R4 load counter
        '{2'd2, 4'd1,  32'd10,  4'd4},
        '{2'd2, 4'd2,  32'd0,   4'd4},
        '{2'd0, 4'd9,  32'd15,  4'd5},  // R5 ch1 comparator
        '{2'd0, 4'd8,  32'd1,   4'd7},  // R7 ch1 enable
        '{2'd0, 4'd0,  32'd1,   4'd2},  // R2 run on
        '{2'd1, 4'd0,  32'd5,   4'd2},
        '{2'd2, 4'd1,  32'd15,  4'd2},
        '{2'd2, 4'd2,  32'd2,   4'd5},
        '{2'd1, 4'd0,  32'd3,   4'd5},
        '{2'd2, 4'd1,  32'd18,  4'd2},
        '{2'd2, 4'd2,  32'd2,   4'd6},  // R6 sticky
        '{2'd0, 4'd2,  32'd2,   4'd6},
        '{2'd2, 4'd2,  32'd0,   4'd6},
        '{2'd0, 4'd0,  32'd0,   4'd8},  // R8 periodic setup
        '{2'd0, 4'd1,  32'd100, 4'd8},
        '{2'd0, 4'd5,  32'd104, 4'd8},
        '{2'd0, 4'd6,  32'd10,  4'd8},
        '{2'd0, 4'd4,  32'd3,   4'd8},
        '{2'd0, 4'd0,  32'd1,   4'd8},
        '{2'd1, 4'd0,  32'd4,   4'd8},
        '{2'd2, 4'd2,  32'd1,   4'd8},
        '{2'd2, 4'd5,  32'd114, 4'd8},
        '{2'd0, 4'd2,  32'd1,   4'd6},
        '{2'd1, 4'd0,  32'd10,  4'd8},
        '{2'd2, 4'd1,  32'd114, 4'd8},
        '{2'd2, 4'd2,  32'd1,   4'd8},
        '{2'd2, 4'd5,  32'd124, 4'd8},
        '{2'd0, 4'd0,  32'd0,   4'd9},  // R9 ch2 one-shot only
        '{2'd0, 4'd12, 32'd3,   4'd9},
        '{2'd2, 4'd12, 32'd1,   4'd9},
        '{2'd0, 4'd14, 32'd7,   4'd9},
        '{2'd2, 4'd14, 32'd0,   4'd9},
        '{2'd0, 4'd13, 32'd130, 4'd9},
        '{2'd0, 4'd2,  32'd7,   4'd6},
        '{2'd0, 4'd0,  32'd1,   4'd9},
        '{2'd1, 4'd0,  32'd16,  4'd9},
        '{2'd2, 4'd1,  32'd130, 4'd2},
        '{2'd2, 4'd2,  32'd5,   4'd9},
        '{2'd2, 4'd13, 32'd130, 4'd9},
        '{2'd2, 4'd5,  32'd134, 4'd8},
        '{2'd0, 4'd2,  32'd7,   4'd6},
        '{2'd2, 4'd2,  32'd0,   4'd6},
        '{2'd2, 4'd4,  32'd3,   4'd10}, // R10 cfg readback
        '{2'd2, 4'd8,  32'd1,   4'd9}
    };

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d: got %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic [2:0] exp, input string req);
        #1;
        n_cmp++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s irq: got %b expected %b", req, irq, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(4'd0, 32'd0, "R1");
        chk(4'd1, 32'd0, "R1");
        chk(4'd2, 32'd0, "R1");
        chk(4'd5, 32'd0, "R1");
        chk_irq(3'b000, "R1");
        chk(4'd3, 32'd0, "R10");

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                2'd0: wr(VECS[i].addr, VECS[i].data);
                2'd1: ticks(int'(VECS[i].data));
                default: chk(VECS[i].addr, VECS[i].data, $sformatf("R%0d", VECS[i].req));
            endcase
        end

        // R3 counter wrap, ch1 matches at 0
        wr(4'd0, 32'd0);
        wr(4'd1, 32'hFFFF_FFFE);
        wr(4'd9, 32'd0);
        wr(4'd0, 32'd1);
        ticks(2);
        chk(4'd1, 32'd0, "R3");
        chk(4'd2, 32'd2, "R5");
        chk_irq(3'b010, "R7");
        ticks(1);
        chk(4'd1, 32'd1, "R3");
        // R7 enable off masks irq, status kept
        wr(4'd8, 32'd0);
        chk_irq(3'b000, "R7");
        chk(4'd2, 32'd2, "R7");
        // R6 writing zeros clears nothing
        wr(4'd2, 32'd0);
        chk(4'd2, 32'd2, "R6");
        // R4 load onto comparator value gives no match
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd7);
        wr(4'd9, 32'd50);
        wr(4'd1, 32'd50);
        chk(4'd1, 32'd50, "R4");
        chk(4'd2, 32'd0, "R4");
        ticks(3);
        chk(4'd1, 32'd50, "R2");
        wr(4'd0, 32'd1);
        repeat (3) @(negedge clk);
        chk(4'd1, 32'd50, "R2");
        // R8 periodic comparator wraps modulo 2^32
        wr(4'd0, 32'd0);
        wr(4'd1, 32'hFFFF_FFFA);
        wr(4'd5, 32'hFFFF_FFFC);
        wr(4'd6, 32'd8);
        wr(4'd2, 32'd7);
        wr(4'd0, 32'd1);
        ticks(2);
        chk(4'd5, 32'd4, "R8");
        chk(4'd2, 32'd1, "R8");
        chk_irq(3'b001, "R7");
        chk(4'd1, 32'hFFFF_FFFC, "R2");
        finish_run();
    end
endmodule